// File: doc/BRIEF.md
# Write-Only Two-Wire Clock Configuration Slave

This block is a receive-only slave on an open-drain two-wire serial bus. It recovers start and stop conditions and serial bits from oversampled copies of the bus clock and data lines. It accepts block writes to one fixed device address. The only thing it ever puts on the data line is the acknowledge bit, through a pull-down enable.

A write transfer carries the address byte, a command byte, a count byte, and then data bytes. The block acknowledges the command and count bytes and throws them away. Data bytes go into a small configuration bank, one register after another, starting at register 0. The master may stop after any complete byte. Registers that were not reached keep their old contents.

The bank drives a gating stage in front of a set of clock outputs. Each output has its own disable bit, which forces that output low. A mode register holds three things: a global output-enable kill, a bypass that routes the crystal clock to every output, and a frequency-select code.

Top module: `sclk_cfg_slave`

## Requirements
- R1: After reset all configuration registers are zero. Every clkOut bit follows its pllClk bit, clkOe is 1, freqSel is 0 and sdaPullDown is 0.
- R2: A start condition is SDA falling while SCL is high. After a start, the byte 0xD2 is the address 1101001 with write bit 0, sent MSB first. The block acknowledges it by asserting sdaPullDown from the fall of SCL after bit 8 to the fall of SCL after bit 9.
- R3: Any other first byte gets no acknowledge. This includes 0xD3, which has the read bit set. After such a byte, no later byte is acknowledged or stored until the next start.
- R4: The second and third bytes of a matched transfer (command and count) are acknowledged and change no register.
- R5: Data bytes are sampled MSB first on rising SCL. The first data byte goes to register 0, the second to register 1 and the third to register 2. Register 0 bit k disables output k. Register 1 bit k disables output 8+k. Register 2 is the mode register.
- R6: A stop condition is SDA rising while SCL is high. A stop after a complete byte ends the transfer, and the registers not yet reached keep their values.
- R7: A byte is stored only at its acknowledge. A partial byte is discarded when a stop or a repeated start cuts it off. A repeated start begins a new address phase.
- R8: When an output's disable bit is 1 and bypass is 0, that clkOut bit is held at 0.
- R9: Mode register bit 7 = 1 drives clkOe to 0. Bit 6 = 1 makes every clkOut bit equal xtalClk, whatever the disable bits say. Bits 2:0 appear on freqSel.
- R10: Data bytes beyond the last register are acknowledged and discarded.
- R11: sdaPullDown is 0 everywhere except the acknowledge slot, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired value) |
| sdaPullDown | output | 1 | Pulls the data line low for acknowledge |
| pllClk | input | NUM_OUT | Clock sources from the synthesiser |
| xtalClk | input | 1 | Crystal reference used in bypass |
| clkOut | output | NUM_OUT | Gated clock outputs |
| clkOe | output | 1 | Output enable shared by all clock outputs |
| freqSel | output | FSEL_W | Frequency select code for the synthesiser |

## Verification
The assertions assume the bus behaves like a real master with an open-drain line. SCL stays low for many more system clocks than the two-flop synchroniser delay. SDA changes only while SCL is low, except for start and stop conditions. The bench meets this by having every bus phase last ten system clocks and by changing the master's data only a full phase after SCL falls. The data line it feeds back is the AND of the master's drive and the inverse of sdaPullDown. Acknowledge bits are read from that wired line in the middle of the ninth SCL high phase.

// File: rtl/sclk_cfg_pkg.sv
package sclk_cfg_pkg;

  localparam int BYTE_BITS = 8;
  localparam int HDR_BYTES = 3;  // address, command, count

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK
  } rxState_t;

  typedef struct packed {
    logic shiftBit;    // sample one data bit into the shift register
    logic commitByte;  // acknowledged byte: advance index, store if data
    logic clearIdx;    // start condition: rewind byte index
  } dpStrobe_t;

endpackage

// File: rtl/sclk_bus_sync.sv
module sclk_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startCond,
  output logic stopCond
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclLvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl    = sclPipe[STAGES-1];
  assign sdaLvl    = sdaPipe[STAGES-1];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startCond = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopCond  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/sclk_rx_ctrl.sv
module sclk_rx_ctrl
  import sclk_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startCond,
  input  logic       stopCond,
  input  logic [7:0] rxByte,
  output dpStrobe_t  strobe,
  output logic       sdaPullDown
);

  localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

  rxState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic           addrPhase;
  logic           byteDone;
  logic           addrOk;

  assign addrOk   = (rxByte == WR_ADDR);
  assign byteDone = (state == ST_RECV) && sclFall && (bitCnt == LAST_BIT);

  always_comb begin
    strobe            = '0;
    strobe.shiftBit   = (state == ST_RECV) && sclRise && (bitCnt != LAST_BIT);
    strobe.commitByte = byteDone && (!addrPhase || addrOk);
    strobe.clearIdx   = startCond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      addrPhase <= 1'b0;
    end else if (startCond) begin
      state     <= ST_RECV;
      bitCnt    <= '0;
      addrPhase <= 1'b1;
    end else if (stopCond) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      addrPhase <= 1'b0;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (strobe.shiftBit) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (byteDone) begin
            if (addrPhase && !addrOk) begin
              state <= ST_IDLE;
            end else begin
              state     <= ST_ACK;
              addrPhase <= 1'b0;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            state  <= ST_RECV;
            bitCnt <= '0;
          end
        end
        default: begin
          bitCnt <= '0;
        end
      endcase
    end
  end

  assign sdaPullDown = (state == ST_ACK);

endmodule

// File: rtl/sclk_rx_datapath.sv
module sclk_rx_datapath
  import sclk_cfg_pkg::*;
#(
  parameter int NUM_REGS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  dpStrobe_t               strobe,
  input  logic                    sdaBit,
  output logic [7:0]              rxByte,
  output logic [NUM_REGS*8-1:0]   regFlat
);

  localparam int IDX_W = $clog2(NUM_REGS + HDR_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] byteIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxByte <= '0;
    end else if (strobe.shiftBit) begin
      rxByte <= {rxByte[6:0], sdaBit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteIdx <= '0;
    end else if (strobe.clearIdx) begin
      byteIdx <= '0;
    end else if (strobe.commitByte && byteIdx != IDX_MAX) begin
      byteIdx <= byteIdx + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(HDR_BYTES + g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regFlat[g*8 +: 8] <= '0;
      end else if (strobe.commitByte && byteIdx == SLOT) begin
        regFlat[g*8 +: 8] <= rxByte;
      end
    end
  end

endmodule

// File: rtl/sclk_out_gate.sv
module sclk_out_gate #(
  parameter int NUM_OUT  = 12,
  parameter int NUM_REGS = 3,
  parameter int FSEL_W   = 3
) (
  input  logic [NUM_REGS*8-1:0] regFlat,
  input  logic [NUM_OUT-1:0]    pllClk,
  input  logic                  xtalClk,
  output logic [NUM_OUT-1:0]    clkOut,
  output logic                  clkOe,
  output logic [FSEL_W-1:0]     freqSel
);

  localparam int MODE_BASE = (NUM_REGS - 1) * 8;
  localparam int OE_KILL   = 7;
  localparam int BYPASS    = 6;

  logic [7:0]         modeByte;
  logic [NUM_OUT-1:0] disMask;
  logic               unusedCfg;

  assign modeByte  = regFlat[MODE_BASE +: 8];
  assign disMask   = regFlat[NUM_OUT-1:0];
  assign unusedCfg = ^regFlat;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    assign clkOut[i] = modeByte[BYPASS] ? xtalClk : (pllClk[i] & ~disMask[i]);
  end

  assign clkOe   = ~modeByte[OE_KILL];
  assign freqSel = modeByte[FSEL_W-1:0];

endmodule

// File: rtl/sclk_cfg_slave.sv
module sclk_cfg_slave
  import sclk_cfg_pkg::*;
#(
  parameter int         NUM_OUT  = 12,
  parameter int         FSEL_W   = 3,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaPullDown,
  input  logic [NUM_OUT-1:0] pllClk,
  input  logic               xtalClk,
  output logic [NUM_OUT-1:0] clkOut,
  output logic               clkOe,
  output logic [FSEL_W-1:0]  freqSel
);

  localparam int DIS_REGS = (NUM_OUT + 7) / 8;
  localparam int NUM_REGS = DIS_REGS + 1;

  logic sdaLvl, sclRise, sclFall, startCond, stopCond;
  logic [7:0] rxByte;
  logic [NUM_REGS*8-1:0] cfgFlat;
  dpStrobe_t strobe;

  sclk_bus_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond)
  );

  sclk_rx_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .rxByte(rxByte),
    .strobe(strobe), .sdaPullDown(sdaPullDown)
  );

  sclk_rx_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sdaBit(sdaLvl),
    .rxByte(rxByte), .regFlat(cfgFlat)
  );

  sclk_out_gate #(.NUM_OUT(NUM_OUT), .NUM_REGS(NUM_REGS), .FSEL_W(FSEL_W)) u_gate (
    .regFlat(cfgFlat), .pllClk(pllClk), .xtalClk(xtalClk),
    .clkOut(clkOut), .clkOe(clkOe), .freqSel(freqSel)
  );

endmodule

// File: rtl/sclk_cfg_slave_chk.sv
module sclk_cfg_slave_chk #(
  parameter int CFG_W  = 24,
  parameter int FSEL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclIn,
  input logic              sdaPullDown,
  input logic [CFG_W-1:0]  cfgFlat,
  input logic              clkOe,
  input logic [FSEL_W-1:0] freqSel
);

  AST_ACK_ENTER_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdaPullDown) |-> !sclIn); // R11

  AST_ACK_LEAVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdaPullDown) |-> !sclIn); // R11

  AST_CFG_ONLY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfgFlat) |-> $rose(sdaPullDown)); // R7

  AST_OE_ONLY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clkOe) |-> $rose(sdaPullDown)); // R9

  AST_FSEL_ONLY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freqSel) |-> $rose(sdaPullDown)); // R9

endmodule

bind sclk_cfg_slave sclk_cfg_slave_chk #(
  .CFG_W(NUM_REGS*8), .FSEL_W(FSEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaPullDown(sdaPullDown),
  .cfgFlat(cfgFlat), .clkOe(clkOe), .freqSel(freqSel)
);

// File: tb/sim_sclk_cfg_slave.sv
module sim_sclk_cfg_slave;

  localparam int NUM_OUT = 12;
  localparam int Q = 10;
  localparam logic [7:0] ADDR_WR = 8'hD2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [NUM_OUT-1:0] pll = '0;
  logic xtal = 1'b0;
  logic sdaPull;
  logic [NUM_OUT-1:0] clkOut;
  logic clkOe;
  logic [2:0] freqSel;
  logic sdaBus;
  assign sdaBus = sdaM & ~sdaPull;

  sclk_cfg_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullDown(sdaPull), .pllClk(pll), .xtalClk(xtal),
    .clkOut(clkOut), .clkOe(clkOe), .freqSel(freqSel)
  );

  int total = 0;
  int bad = 0;
  bit expAck[$];
  string ackTag[$];
  event ackEv;
  logic [7:0] expReg [3];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares acknowledge slots as they occur
  initial begin
    forever begin
      @(ackEv);
      #1;
      if (ackTag.size() > 0) begin
        string t;
        bit e;
        t = ackTag.pop_front();
        e = expAck.pop_front();
        chk(t, {31'd0, ~sdaBus}, {31'd0, e});
      end
    end
  end

  task automatic phase();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sdaM = 1'b1; phase();
    sclM = 1'b1; phase();
    sdaM = 1'b0; phase();
    sclM = 1'b0; phase();
  endtask

  task automatic bus_stop();
    sdaM = 1'b0; phase();
    sclM = 1'b1; phase();
    sdaM = 1'b1; phase();
  endtask

  task automatic send_bit(input logic b);
    sdaM = b; phase();
    sclM = 1'b1; phase();
    chk("R11 no pull in data bit", {31'd0, sdaPull}, 32'd0);
    phase();
    sclM = 1'b0; phase();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sdaM = 1'b1; phase();
    sclM = 1'b1; phase();
    expAck.push_back(ack);
    ackTag.push_back(tag);
    ->ackEv;
    phase();
    sclM = 1'b0; phase();
  endtask

  task automatic check_outputs(input string tag);
    for (int p = 0; p < 2; p++) begin
      logic [NUM_OUT-1:0] dis, expOut;
      pll  = (p == 0) ? 12'hFFF : 12'hA5C;
      xtal = (p == 1);
      @(negedge clk);
      dis    = {expReg[1][3:0], expReg[0]};
      expOut = expReg[2][6] ? {NUM_OUT{xtal}} : (pll & ~dis);
      chk({tag, " clkOut"}, {20'd0, clkOut}, {20'd0, expOut});
      chk({tag, " clkOe"}, {31'd0, clkOe}, {31'd0, ~expReg[2][7]});
      chk({tag, " freqSel"}, {29'd0, freqSel}, {29'd0, expReg[2][2:0]});
    end
  endtask

  task automatic header(input string tag);
    bus_start();
    send_byte(ADDR_WR, 1'b1, {tag, " R2 addr ack"});
    send_byte(8'h5A, 1'b1, {tag, " R4 cmd ack"});
    send_byte(8'h03, 1'b1, {tag, " R4 count ack"});
  endtask

  initial begin
    for (int i = 0; i < 3; i++) expReg[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pulldown idle", {31'd0, sdaPull}, 32'd0);
    check_outputs("R1 reset");

    // full block write
    header("full");
    send_byte(8'h81, 1'b1, "R5 d0 ack");
    send_byte(8'h02, 1'b1, "R5 d1 ack");
    send_byte(8'h05, 1'b1, "R5 d2 ack");
    bus_stop();
    expReg[0] = 8'h81; expReg[1] = 8'h02; expReg[2] = 8'h05;
    check_outputs("R5/R8/R4 full write");

    // stop after one data byte
    header("short");
    send_byte(8'h00, 1'b1, "R6 d0 ack");
    bus_stop();
    expReg[0] = 8'h00;
    check_outputs("R6 early stop");

    // partial byte cut by stop
    header("part");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    check_outputs("R7 partial stop");

    // partial byte cut by repeated start
    header("rs");
    send_byte(8'hFF, 1'b1, "R7 d0 ack");
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    expReg[0] = 8'hFF;
    header("rs2");
    send_byte(8'h10, 1'b1, "R7 d0 after restart");
    bus_stop();
    expReg[0] = 8'h10;
    check_outputs("R7 repeated start");

    // wrong address
    bus_start();
    send_byte(8'hD0, 1'b0, "R3 wrong addr nack");
    send_byte(8'h5A, 1'b0, "R3 cmd ignored");
    send_byte(8'h03, 1'b0, "R3 count ignored");
    send_byte(8'hFF, 1'b0, "R3 data ignored");
    bus_stop();
    check_outputs("R3 wrong addr");

    // read bit set
    bus_start();
    send_byte(8'hD3, 1'b0, "R3 read nack");
    send_byte(8'hEE, 1'b0, "R3 data after read");
    bus_stop();
    check_outputs("R3 read addr");

    // over-length, bypass mode
    header("long");
    send_byte(8'h00, 1'b1, "R10 d0");
    send_byte(8'h0F, 1'b1, "R10 d1");
    send_byte(8'h46, 1'b1, "R10 d2");
    send_byte(8'hFF, 1'b1, "R10 extra1 ack");
    send_byte(8'hFF, 1'b1, "R10 extra2 ack");
    bus_stop();
    expReg[0] = 8'h00; expReg[1] = 8'h0F; expReg[2] = 8'h46;
    check_outputs("R9/R10 bypass");

    // tristate
    header("tri");
    send_byte(8'h0F, 1'b1, "R9 d0");
    send_byte(8'h00, 1'b1, "R9 d1");
    send_byte(8'h83, 1'b1, "R9 d2");
    bus_stop();
    expReg[0] = 8'h0F; expReg[1] = 8'h00; expReg[2] = 8'h83;
    check_outputs("R9/R8 tristate");
    chk("R11 pulldown after stop", {31'd0, sdaPull}, 32'd0);

    repeat (20) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule